// File: doc/BRIEF.md
# Variable-latency issue and write-back sequencer

This block decides, once per cycle, whether the operation on its issue port may start execution, and tells the register file when each started operation writes its result back. Operations start in program order. Each one goes to one of four execution classes:

- integer/memory, one execute cycle;
- floating-point add, four cycles;
- floating-point multiply, seven cycles;
- floating-point divide, twenty-five cycles.

Every operation then spends one memory cycle and one write-back cycle. Because these latencies differ, results can return in a different order from the order of issue.

The block keeps a pending bit for each destination register. It also keeps a list of the write-back slots that are already booked and a busy count for the single divider. It holds the operation on the port when any of these would be broken:

- a source register is not ready;
- the destination register already has a write in flight;
- the write-back port is already booked for the cycle in which this operation would finish;
- the divider is busy and the operation is a divide.

The datapath, memory and register contents are outside this block. Only timing and tags are handled.

Top module: `fp_issue_tracker`

## Requirements
- R1: The class code is 2 bits. Code 0 (integer/memory), accepted in cycle t, gives a one-cycle pulse on wb_valid in cycle t+2, with wb_tag equal to its destination.
- R2: Code 1 (FP add), accepted in cycle t, writes back in cycle t+5.
- R3: Code 2 (FP multiply), accepted in cycle t, writes back in cycle t+8.
- R4: Code 3 (FP divide), accepted in cycle t, writes back in cycle t+26.
- R5: After a divide is accepted in cycle t, no other divide is accepted before cycle t+25. Operations of other classes are still accepted during that time.
- R6: Add and multiply operations can be accepted in consecutive cycles.
- R7: An operation is held while a source that it marks as used (iss_use_a or iss_use_b high) names a register still waiting for write-back. A source that is marked unused has no effect on acceptance.
- R8: An operation is held while its destination register still waits for an earlier write-back.
- R9: An operation is held when its write-back cycle would equal a cycle that is already booked. It is accepted in the first cycle where that does not happen.
- R10: Results may write back in a different order from issue. Each write-back is one pulse with its own tag.
- R11: A synchronous reset cancels all pending write-backs, clears every register's pending bit and frees the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is offered on the issue port |
| iss_cls | input | 2 | Execution class: 0 integer/memory, 1 add, 2 multiply, 3 divide |
| iss_dst | input | 5 | Destination register tag |
| iss_src_a | input | 5 | First source register tag |
| iss_use_a | input | 1 | First source is read by the operation |
| iss_src_b | input | 5 | Second source register tag |
| iss_use_b | input | 1 | Second source is read by the operation |
| iss_ready | output | 1 | Offered operation may start this cycle (accepted when iss_valid is also high) |
| wb_valid | output | 1 | A result writes back this cycle |
| wb_tag | output | 5 | Destination register of the result writing back |

## Verification
A pending bit stuck high shows at the ports as iss_ready held low for ever on any operation that names that register. A pending bit lost early shows as iss_ready rising before the matching wb_valid pulse. A booking slot that is off by one moves the wb_valid pulse one cycle away from the latency of its class. This is visible exactly 2, 5, 8 or 26 cycles after acceptance. A wrong divider count moves the acceptance cycle of a second divide away from 25 cycles after the first.

// File: rtl/fp_issue_tracker.sv
`timescale 1ns/1ps
module fp_issue_tracker #(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 7,
  parameter int LAT_DIV = 25,
  parameter int TW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [1:0]    iss_cls,
  input  logic [TW-1:0] iss_dst,
  input  logic [TW-1:0] iss_src_a,
  input  logic          iss_use_a,
  input  logic [TW-1:0] iss_src_b,
  input  logic          iss_use_b,
  output logic          iss_ready,
  output logic          wb_valid,
  output logic [TW-1:0] wb_tag
);
  localparam int DI = LAT_INT + 1;
  localparam int DA = LAT_ADD + 1;
  localparam int DM = LAT_MUL + 1;
  localparam int DV = LAT_DIV + 1;
  localparam int M1 = (DA > DI) ? DA : DI;
  localparam int M2 = (DM > M1) ? DM : M1;
  localparam int NS = (DV > M2) ? DV : M2;
  localparam int SW = $clog2(NS + 1);
  localparam int CW = $clog2(LAT_DIV + 1);

  logic [NS:0]     sv;
  logic [TW-1:0]   st [NS+1];
  logic [NREG-1:0] pend;
  logic [CW-1:0]   dcnt;
  logic [SW-1:0]   dly;
  logic            src_hold, is_div, fire;

  always_comb begin
    case (iss_cls)
      2'd0:    dly = SW'(DI);
      2'd1:    dly = SW'(DA);
      2'd2:    dly = SW'(DM);
      default: dly = SW'(DV);
    endcase
  end

  assign is_div    = (iss_cls == 2'd3);
  assign src_hold  = (iss_use_a && pend[iss_src_a]) || (iss_use_b && pend[iss_src_b]);
  assign iss_ready = !src_hold && !pend[iss_dst] && !sv[dly] && !(is_div && dcnt != '0);
  assign fire      = iss_valid && iss_ready;
  assign wb_valid  = sv[0];
  assign wb_tag    = st[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sv   <= '0;
      pend <= '0;
      dcnt <= '0;
      for (int j = 0; j <= NS; j++) st[j] <= '0;
    end else begin
      for (int j = 0; j < NS; j++) begin
        sv[j] <= sv[j+1];
        st[j] <= st[j+1];
      end
      sv[NS] <= 1'b0;
      st[NS] <= '0;
      if (sv[0]) pend[st[0]] <= 1'b0;
      if (fire) begin
        sv[dly - SW'(1)] <= 1'b1;
        st[dly - SW'(1)] <= iss_dst;
        pend[iss_dst]    <= 1'b1;
      end
      if (fire && is_div)  dcnt <= CW'(LAT_DIV - 1);
      else if (dcnt != '0) dcnt <= dcnt - CW'(1);
    end
  end
endmodule

// File: rtl/fp_issue_tracker_chk.sv
`timescale 1ns/1ps
module fp_issue_tracker_chk #(
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          iss_valid,
  input logic [1:0]    iss_cls,
  input logic [TW-1:0] iss_dst,
  input logic          iss_ready,
  input logic          wb_valid,
  input logic [TW-1:0] wb_tag
);
  logic fire;
  assign fire = iss_valid && iss_ready;

  // R1
  int_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && iss_cls == 2'd0) |-> ##2 (wb_valid && wb_tag == $past(iss_dst, 2)));

  // R2
  add_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && iss_cls == 2'd1) |-> ##5 (wb_valid && wb_tag == $past(iss_dst, 5)));

  // R5
  div_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && iss_cls == 2'd3) |=> !(iss_valid && iss_ready && iss_cls == 2'd3));

  // R8
  waw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !(iss_valid && iss_ready && iss_dst == $past(iss_dst)));

  // R11
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !wb_valid);
endmodule

bind fp_issue_tracker fp_issue_tracker_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_cls(iss_cls),
  .iss_dst(iss_dst), .iss_ready(iss_ready), .wb_valid(wb_valid), .wb_tag(wb_tag)
);

// File: tb/sim_fp_issue_tracker.sv
`timescale 1ns/1ps
module sim_fp_issue_tracker;
  logic clk = 0, rst = 1;
  logic iss_valid = 0, iss_use_a = 0, iss_use_b = 0;
  logic [1:0] iss_cls = 0;
  logic [4:0] iss_dst = 0, iss_src_a = 0, iss_src_b = 0;
  logic iss_ready, wb_valid;
  logic [4:0] wb_tag;
  int errors = 0, checks = 0, cyc = 0, base = 0, nev = 0;
  int ev_cyc [64];
  int ev_tag [64];
  bit logging = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_issue_tracker u0 (.*);

  // fields: cls[38:37] dst[36:32] sa[31:27] sb[26:22] ua[21] ub[20] req[19:16] issue[15:8] wb[7:0]
  localparam int NV = 17;
  localparam logic [38:0] VEC [NV] = '{
    {2'd2, 5'd2,  5'd0,  5'd0,  1'b0, 1'b0, 4'd3,  8'd0,  8'd8},
    {2'd1, 5'd4,  5'd0,  5'd0,  1'b0, 1'b0, 4'd2,  8'd1,  8'd6},
    {2'd0, 5'd6,  5'd0,  5'd0,  1'b0, 1'b0, 4'd1,  8'd2,  8'd4},
    {2'd1, 5'd8,  5'd4,  5'd0,  1'b1, 1'b0, 4'd7,  8'd7,  8'd12},
    {2'd0, 5'd10, 5'd2,  5'd0,  1'b1, 1'b0, 4'd7,  8'd9,  8'd11},
    {2'd1, 5'd12, 5'd0,  5'd0,  1'b0, 1'b0, 4'd2,  8'd10, 8'd15},
    {2'd2, 5'd14, 5'd0,  5'd0,  1'b0, 1'b0, 4'd6,  8'd11, 8'd19},
    {2'd1, 5'd16, 5'd0,  5'd0,  1'b0, 1'b0, 4'd6,  8'd12, 8'd17},
    {2'd0, 5'd18, 5'd0,  5'd0,  1'b0, 1'b0, 4'd9,  8'd14, 8'd16},
    {2'd0, 5'd16, 5'd0,  5'd0,  1'b0, 1'b0, 4'd8,  8'd18, 8'd20},
    {2'd3, 5'd20, 5'd0,  5'd0,  1'b0, 1'b0, 4'd4,  8'd19, 8'd45},
    {2'd1, 5'd23, 5'd0,  5'd0,  1'b0, 1'b0, 4'd5,  8'd20, 8'd25},
    {2'd3, 5'd22, 5'd0,  5'd0,  1'b0, 1'b0, 4'd5,  8'd44, 8'd70},
    {2'd0, 5'd24, 5'd0,  5'd22, 1'b0, 1'b1, 4'd7,  8'd71, 8'd73},
    {2'd0, 5'd26, 5'd24, 5'd0,  1'b0, 1'b0, 4'd7,  8'd72, 8'd74},
    {2'd2, 5'd1,  5'd0,  5'd0,  1'b0, 1'b0, 4'd6,  8'd73, 8'd81},
    {2'd2, 5'd3,  5'd0,  5'd0,  1'b0, 1'b0, 4'd6,  8'd74, 8'd82}
  };

  function automatic string rq(int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(logic [1:0] c, logic [4:0] d, logic [4:0] a, logic ua);
    iss_valid = 1; iss_cls = c; iss_dst = d; iss_src_a = a; iss_use_a = ua;
    iss_src_b = 0; iss_use_b = 0;
  endtask

  always @(negedge clk)
    if (logging && wb_valid && nev < 64) begin
      ev_cyc[nev] = cyc - base;
      ev_tag[nev] = wb_tag;
      nev++;
    end

  initial begin
    #80000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wb_valid == 0, "R11", wb_valid, 0);
    rst = 0;
    @(negedge clk);
    offer(2'd3, 5'd0, 5'd0, 0);
    #1 chk(iss_ready == 1, "R11", iss_ready, 1);
    iss_valid = 0;
    @(negedge clk);
    base = cyc; logging = 1;
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      int w;
      v = VEC[i];
      iss_valid = 1; iss_cls = v[38:37]; iss_dst = v[36:32];
      iss_src_a = v[31:27]; iss_src_b = v[26:22]; iss_use_a = v[21]; iss_use_b = v[20];
      w = 0;
      #1;
      while (!iss_ready && w < 200) begin
        @(negedge clk); #1; w++;
      end
      chk((cyc - base) == int'(v[15:8]), rq(int'(v[19:16])), cyc - base, int'(v[15:8]));
      @(negedge clk);
    end
    iss_valid = 0;
    while (cyc - base < 90) @(negedge clk);
    logging = 0;
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      bit hit;
      v = VEC[i];
      hit = 0;
      for (int k = 0; k < nev; k++)
        if (ev_tag[k] == int'(v[36:32]) && ev_cyc[k] == int'(v[7:0])) hit = 1;
      // R10: each result pulses once at its own cycle, out of issue order
      chk(hit, (v[38:37] == 2'd0) ? "R1" : (v[38:37] == 2'd1) ? "R2" :
               (v[38:37] == 2'd2) ? "R3" : "R4", hit, 1);
    end
    chk(nev == NV, "R10", nev, NV);

    // R11: reset mid-flight drops a multiply result and frees its register
    @(negedge clk);
    offer(2'd2, 5'd5, 5'd0, 0);
    @(negedge clk); iss_valid = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    begin
      int seen;
      seen = 0;
      offer(2'd0, 5'd7, 5'd5, 1);
      #1 chk(iss_ready == 1, "R11", iss_ready, 1);
      iss_valid = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (wb_valid && wb_tag == 5'd5) seen++;
      end
      chk(seen == 0, "R11", seen, 0);
    end
    // R11: reset frees a busy divider
    @(negedge clk);
    offer(2'd3, 5'd9, 5'd0, 0);
    #1 chk(iss_ready == 1, "R5", iss_ready, 1);
    @(negedge clk);
    offer(2'd3, 5'd11, 5'd0, 0);
    #1 chk(iss_ready == 0, "R5", iss_ready, 0);
    iss_valid = 0;
    rst = 1;
    @(negedge clk); rst = 0;
    offer(2'd3, 5'd11, 5'd0, 0);
    #1 chk(iss_ready == 1, "R11", iss_ready, 1);
    iss_valid = 0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule